// File: doc/BRIEF.md
# FPGA Configuration Port Controller

This block sits between a host register write port and the configuration control block of a programmable fabric. It keeps a control word that decides who drives the configuration inputs: the external configuration pins, or the host through this block. Three host pull requests pull the active-low reset, status and done lines low at all times, whoever is in control. While the host is in control, the block also drives chip enable and the partial-reconfiguration request from the control word.

Configuration data arrives as 32-bit words on a valid/ready stream. Each accepted word goes out on the configuration data bus, either whole (32-bit mode) or as two 16-bit halves (16-bit mode). The block produces a configuration clock with a programmable number of pulses per word or half-word. That clock can be switched off separately, and words are still accepted and acknowledged at the same rate, so host writes never stall.

Top module: `fpga_cfg_port`

## Requirements
- R1: After a synchronous active-low reset, the control word reads as zero and `inReady` is 1. With the control word at zero, all configuration outputs follow the pins.
- R2: Writing with `regWe` stores `regWdata[9:0]`, which `regRdata` shows from the next cycle. Bits 31:10 always read 0.
- R3: With bit 0 (source select) at 0, `cbNce`, `cbPrReq`, `cbDclk` and `cbData` pass `pinNce`, `pinPrReq`, `pinDclk` and `pinData` through unchanged.
- R4: With bit 0 at 1, `cbNce` equals bit 1 and `cbPrReq` equals bit 5. `cbDclk` and `cbData` come from the stream.
- R5: Bits 2, 3 and 4 each pull one line low: `cbNConfig`, `cbNStatus` and `cbConfDone` respectively. Each line is its pin AND NOT its pull bit, whatever the value of bit 0.
- R6: Bits 7:6 select the pulses per word or half-word: 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 8. Each pulse is high for one clock cycle and then low for one.
- R7: While bit 0 is 1 and bit 8 (clock enable) is 0, `cbDclk` stays low. Words are still accepted, and `inReady` follows exactly the same timing as with the clock enabled.
- R8: Bit 9 = 1 sends the whole word on `cbData`. Bit 9 = 0 sends bits 15:0 first, then bits 31:16, each on `cbData[15:0]` with `cbData[31:16]` at 0. Each half gets the full pulse count.
- R9: After a word is accepted, `inReady` is low for exactly 2·N·H cycles, where N is the pulse count and H is 1 for 32-bit mode or 2 for 16-bit mode. `cbData` holds steady across each pulse.
- R10: The ratio and the width are captured when a word is accepted. If the control word changes while a word is being sent, the change applies from the next word onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| regWe | input | 1 | Control word write strobe |
| regWdata | input | 32 | Control word write data |
| regRdata | output | 32 | Stored control word |
| inValid | input | 1 | Stream word valid |
| inData | input | 32 | Stream configuration word |
| inReady | output | 1 | Stream ready |
| pinNConfig | input | 1 | External active-low reconfigure line |
| pinNStatus | input | 1 | External active-low status line |
| pinConfDone | input | 1 | External done line |
| pinNce | input | 1 | External active-low chip enable |
| pinPrReq | input | 1 | External partial-reconfiguration request |
| pinDclk | input | 1 | External configuration clock |
| pinData | input | 32 | External configuration data |
| cbNConfig | output | 1 | Reconfigure line to control block |
| cbNStatus | output | 1 | Status line to control block |
| cbConfDone | output | 1 | Done line to control block |
| cbNce | output | 1 | Chip enable to control block |
| cbPrReq | output | 1 | Partial-reconfiguration request to control block |
| cbDclk | output | 1 | Configuration clock to control block |
| cbData | output | 32 | Configuration data to control block |

## Verification
The pin-facing outputs are combinational, so they change in the same cycle the pins change and from the cycle after a register write. The bench drives every input at the falling edge and reads these outputs at the next falling edge. For a word accepted at rising edge P0, the first clock pulse is high in the cycle after P0, and pulse k of the word is high in cycle 2k−1 counted from P0. `inReady` returns in cycle 2·N·H+1. The stream tasks count falling edges from the accepting edge and compare each cycle's clock level, data and ready with these expected positions.

// File: rtl/fpga_cfg_pkg.sv
package fpga_cfg_pkg;
  localparam int CTRL_W        = 32;
  localparam int BIT_SRC       = 0;
  localparam int BIT_NCE       = 1;
  localparam int BIT_PULL_NCFG = 2;
  localparam int BIT_PULL_STAT = 3;
  localparam int BIT_PULL_DONE = 4;
  localparam int BIT_PRREQ     = 5;
  localparam int BIT_RATIO_LO  = 6;
  localparam int RATIO_SEL_W   = 2;
  localparam int BIT_DCLK_EN   = BIT_RATIO_LO + RATIO_SEL_W;
  localparam int BIT_WIDE      = BIT_DCLK_EN + 1;
  localparam int USED_BITS     = BIT_WIDE + 1;

  typedef struct packed {
    logic                   dclkEn;
    logic                   wide;
    logic [RATIO_SEL_W-1:0] ratioSel;
  } cfgStrobes_t;
endpackage

// File: rtl/cfg_ctrl_regs.sv
module cfg_ctrl_regs
  import fpga_cfg_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWe,
  input  logic [CTRL_W-1:0]    regWdata,
  output logic [CTRL_W-1:0]    regRdata,
  input  logic                 pinNConfig,
  input  logic                 pinNStatus,
  input  logic                 pinConfDone,
  input  logic                 pinNce,
  input  logic                 pinPrReq,
  input  logic                 pinDclk,
  input  logic [WORD_W-1:0]    pinData,
  input  logic                 streamDclk,
  input  logic [WORD_W-1:0]    streamData,
  output logic                 cbNConfig,
  output logic                 cbNStatus,
  output logic                 cbConfDone,
  output logic                 cbNce,
  output logic                 cbPrReq,
  output logic                 cbDclk,
  output logic [WORD_W-1:0]    cbData,
  output cfgStrobes_t          strobes
);
  logic [USED_BITS-1:0] ctrlWord;
  logic                 unusedHi;
  logic                 hostOwns;

  assign unusedHi = ^regWdata[CTRL_W-1:USED_BITS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlWord <= '0;
    end else if (regWe) begin
      ctrlWord <= regWdata[USED_BITS-1:0];
    end
  end

  assign regRdata = {{(CTRL_W-USED_BITS){1'b0}}, ctrlWord};
  assign hostOwns = ctrlWord[BIT_SRC];

  // Pull requests are active-high; lines are active-low, so a pull clears the line.
  assign cbNConfig  = pinNConfig  & ~ctrlWord[BIT_PULL_NCFG];
  assign cbNStatus  = pinNStatus  & ~ctrlWord[BIT_PULL_STAT];
  assign cbConfDone = pinConfDone & ~ctrlWord[BIT_PULL_DONE];

  always_comb begin
    if (hostOwns) begin
      cbNce   = ctrlWord[BIT_NCE];
      cbPrReq = ctrlWord[BIT_PRREQ];
      cbDclk  = streamDclk;
      cbData  = streamData;
    end else begin
      cbNce   = pinNce;
      cbPrReq = pinPrReq;
      cbDclk  = pinDclk;
      cbData  = pinData;
    end
  end

  assign strobes.dclkEn   = ctrlWord[BIT_DCLK_EN];
  assign strobes.wide     = ctrlWord[BIT_WIDE];
  assign strobes.ratioSel = ctrlWord[BIT_RATIO_LO +: RATIO_SEL_W];
endmodule

// File: rtl/cfg_data_streamer.sv
module cfg_data_streamer
  import fpga_cfg_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobes_t       strobes,
  input  logic              inValid,
  input  logic [WORD_W-1:0] inData,
  output logic              inReady,
  output logic              dclkOut,
  output logic [WORD_W-1:0] dataOut
);
  localparam int HALF_W     = WORD_W / 2;
  localparam int MAX_PULSES = 1 << ((1 << RATIO_SEL_W) - 1);
  localparam int CNT_W      = (MAX_PULSES > 1) ? $clog2(MAX_PULSES) : 1;

  logic                   busy;
  logic                   dclkPh;
  logic                   halfSel;
  logic                   wideLat;
  logic [RATIO_SEL_W-1:0] ratioLat;
  logic [CNT_W-1:0]       pulseCnt;
  logic [CNT_W-1:0]       lastCnt;
  logic [WORD_W-1:0]      wordReg;
  logic                   lastPulse;
  logic                   lastHalf;

  assign lastCnt   = CNT_W'((1 << ratioLat) - 1);
  assign lastPulse = (pulseCnt == lastCnt);
  assign lastHalf  = wideLat | halfSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      dclkPh   <= 1'b0;
      halfSel  <= 1'b0;
      wideLat  <= 1'b0;
      ratioLat <= '0;
      pulseCnt <= '0;
      wordReg  <= '0;
    end else if (!busy) begin
      if (inValid) begin
        busy     <= 1'b1;
        dclkPh   <= 1'b1;
        halfSel  <= 1'b0;
        pulseCnt <= '0;
        wordReg  <= inData;
        wideLat  <= strobes.wide;
        ratioLat <= strobes.ratioSel;
      end
    end else if (dclkPh) begin
      dclkPh <= 1'b0;
    end else if (!lastPulse) begin
      pulseCnt <= pulseCnt + 1'b1;
      dclkPh   <= 1'b1;
    end else if (!lastHalf) begin
      halfSel  <= 1'b1;
      pulseCnt <= '0;
      dclkPh   <= 1'b1;
    end else begin
      busy <= 1'b0;
    end
  end

  assign inReady = ~busy;
  assign dclkOut = busy & dclkPh & strobes.dclkEn;

  always_comb begin
    if (halfSel)      dataOut = {{(WORD_W-HALF_W){1'b0}}, wordReg[WORD_W-1:HALF_W]};
    else if (wideLat) dataOut = wordReg;
    else              dataOut = {{(WORD_W-HALF_W){1'b0}}, wordReg[HALF_W-1:0]};
  end
endmodule

// File: rtl/fpga_cfg_port.sv
module fpga_cfg_port
  import fpga_cfg_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              inValid,
  input  logic [WORD_W-1:0] inData,
  output logic              inReady,
  input  logic              pinNConfig,
  input  logic              pinNStatus,
  input  logic              pinConfDone,
  input  logic              pinNce,
  input  logic              pinPrReq,
  input  logic              pinDclk,
  input  logic [WORD_W-1:0] pinData,
  output logic              cbNConfig,
  output logic              cbNStatus,
  output logic              cbConfDone,
  output logic              cbNce,
  output logic              cbPrReq,
  output logic              cbDclk,
  output logic [WORD_W-1:0] cbData
);
  cfgStrobes_t       strobes;
  logic              streamDclk;
  logic [WORD_W-1:0] streamData;

  cfg_ctrl_regs #(.WORD_W(WORD_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata),
    .pinNConfig(pinNConfig), .pinNStatus(pinNStatus), .pinConfDone(pinConfDone),
    .pinNce(pinNce), .pinPrReq(pinPrReq), .pinDclk(pinDclk), .pinData(pinData),
    .streamDclk(streamDclk), .streamData(streamData),
    .cbNConfig(cbNConfig), .cbNStatus(cbNStatus), .cbConfDone(cbConfDone),
    .cbNce(cbNce), .cbPrReq(cbPrReq), .cbDclk(cbDclk), .cbData(cbData),
    .strobes(strobes)
  );

  cfg_data_streamer #(.WORD_W(WORD_W)) i_stream (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .inValid(inValid), .inData(inData), .inReady(inReady),
    .dclkOut(streamDclk), .dataOut(streamData)
  );
endmodule

// File: rtl/fpga_cfg_port_chk.sv
module fpga_cfg_port_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic [31:0]       regWdata,
  input logic [31:0]       regRdata,
  input logic              inValid,
  input logic              inReady,
  input logic              cbDclk,
  input logic [WORD_W-1:0] cbData
);
  assert_reg_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    regWe |=> regRdata[9:0] == $past(regWdata[9:0]));

  assert_pulse_one_high_R6: assert property (@(posedge clk) disable iff (!rstN)
    (regRdata[0] && cbDclk) |=> !(regRdata[0] && cbDclk));

  assert_gated_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    (regRdata[0] && !regRdata[8]) |-> !cbDclk);

  assert_ready_drops_R9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !inReady);

  assert_data_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regRdata[0] && $past(regRdata[0]) && $past(cbDclk)) |-> $stable(cbData));
endmodule

bind fpga_cfg_port fpga_cfg_port_chk #(.WORD_W(WORD_W)) i_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata),
  .inValid(inValid), .inReady(inReady), .cbDclk(cbDclk), .cbData(cbData)
);

// File: tb/test_fpga_cfg_port.sv
module test_fpga_cfg_port;
  logic        clk = 1'b0;
  logic        rstN;
  logic        regWe;
  logic [31:0] regWdata;
  logic [31:0] regRdata;
  logic        inValid;
  logic [31:0] inData;
  logic        inReady;
  logic        pinNConfig, pinNStatus, pinConfDone, pinNce, pinPrReq, pinDclk;
  logic [31:0] pinData;
  logic        cbNConfig, cbNStatus, cbConfDone, cbNce, cbPrReq, cbDclk;
  logic [31:0] cbData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fpga_cfg_port i_fpga_cfg_port (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata),
    .inValid(inValid), .inData(inData), .inReady(inReady),
    .pinNConfig(pinNConfig), .pinNStatus(pinNStatus), .pinConfDone(pinConfDone),
    .pinNce(pinNce), .pinPrReq(pinPrReq), .pinDclk(pinDclk), .pinData(pinData),
    .cbNConfig(cbNConfig), .cbNStatus(cbNStatus), .cbConfDone(cbConfDone),
    .cbNce(cbNce), .cbPrReq(cbPrReq), .cbDclk(cbDclk), .cbData(cbData)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkCtrl(input bit src, input bit nce, input logic [2:0] pulls,
                                         input bit prq, input logic [1:0] ratio, input bit clkOn,
                                         input bit wide);
    return {22'd0, wide, clkOn, ratio, prq, pulls, nce, src};
  endfunction

  task automatic writeCtrl(input logic [31:0] v);
    @(negedge clk);
    regWe = 1'b1; regWdata = v;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  // Sends one word and checks clock, data and ready cycle by cycle.
  task automatic streamWord(input logic [31:0] d, input int n, input bit wide, input bit clkOn,
                            input bit midWrite, input logic [31:0] midCtrl, input string tag);
    int halves = wide ? 1 : 2;
    int lowCnt = 0;
    int pulses = 0;
    int bad = 0;
    logic [31:0] expD;
    @(negedge clk);
    inValid = 1'b1; inData = d;
    @(negedge clk);
    inValid = 1'b0; inData = 32'hDEAD_BEEF;
    if (midWrite) begin regWe = 1'b1; regWdata = midCtrl; end
    for (int k = 1; k <= 40; k++) begin
      if (inReady) break;
      lowCnt++;
      if (cbDclk) pulses++;
      if (cbDclk !== (clkOn && (k % 2 == 1))) bad++;
      if (wide) expD = d;
      else if ((k - 1) / (2 * n) == 0) expD = {16'd0, d[15:0]};
      else expD = {16'd0, d[31:16]};
      if (cbData !== expD) bad++;
      @(negedge clk);
      regWe = 1'b0;
    end
    check(lowCnt == 2 * n * halves, {tag, " R9 ready low cycles"}, lowCnt, 2 * n * halves);
    check(pulses == (clkOn ? n * halves : 0), {tag, " R6 pulse count"}, pulses, clkOn ? n * halves : 0);
    check(bad == 0, {tag, " R8 per-cycle clock/data"}, bad, 0);
  endtask

  task automatic testReset;
    check(regRdata === 32'd0, "R1 control word after reset", regRdata, 0);
    check(inReady === 1'b1, "R1 ready after reset", inReady, 1);
    check({cbNConfig, cbNStatus, cbConfDone, cbNce, cbPrReq, cbDclk} === 6'b101011,
          "R1 outputs follow pins", {cbNConfig, cbNStatus, cbConfDone, cbNce, cbPrReq, cbDclk}, 6'b101011);
  endtask

  task automatic testRegs;
    writeCtrl(32'hFFFF_FFFF);
    check(regRdata === 32'h0000_03FF, "R2 upper bits read zero", regRdata, 32'h3FF);
    writeCtrl(32'h0000_0156);
    check(regRdata === 32'h0000_0156, "R2 readback", regRdata, 32'h156);
    writeCtrl(32'd0);
  endtask

  task automatic testPassThrough;
    @(negedge clk);
    pinNce = 1'b0; pinPrReq = 1'b1; pinDclk = 1'b1; pinData = 32'hA5A5_1234;
    writeCtrl(mkCtrl(0, 1, 3'b000, 0, 2'd3, 1, 1));
    check({cbNce, cbPrReq, cbDclk} === 3'b011, "R3 control pins pass", {cbNce, cbPrReq, cbDclk}, 3'b011);
    check(cbData === 32'hA5A5_1234, "R3 data passes", cbData, 32'hA5A5_1234);
    @(negedge clk);
    pinNce = 1'b1; pinPrReq = 1'b0; pinDclk = 1'b0; pinData = 32'h0F0F_F0F0;
    @(negedge clk);
    check({cbNce, cbPrReq, cbDclk} === 3'b100, "R3 pins change", {cbNce, cbPrReq, cbDclk}, 3'b100);
    check(cbData === 32'h0F0F_F0F0, "R3 data change", cbData, 32'h0F0F_F0F0);
  endtask

  task automatic testHostOwns;
    writeCtrl(mkCtrl(1, 0, 3'b000, 1, 2'd0, 1, 1));
    check({cbNce, cbPrReq} === 2'b01, "R4 nce=0 prreq=1", {cbNce, cbPrReq}, 2'b01);
    writeCtrl(mkCtrl(1, 1, 3'b000, 0, 2'd0, 1, 1));
    check({cbNce, cbPrReq} === 2'b10, "R4 nce=1 prreq=0", {cbNce, cbPrReq}, 2'b10);
    check(cbDclk === 1'b0, "R4 idle clock low", cbDclk, 0);
  endtask

  task automatic testPulls;
    @(negedge clk);
    pinNConfig = 1'b1; pinNStatus = 1'b1; pinConfDone = 1'b1;
    writeCtrl(mkCtrl(0, 0, 3'b101, 0, 2'd0, 0, 0));
    check({cbNConfig, cbNStatus, cbConfDone} === 3'b010, "R5 pulls with src=0",
          {cbNConfig, cbNStatus, cbConfDone}, 3'b010);
    writeCtrl(mkCtrl(1, 0, 3'b010, 0, 2'd0, 0, 0));
    check({cbNConfig, cbNStatus, cbConfDone} === 3'b101, "R5 pulls with src=1",
          {cbNConfig, cbNStatus, cbConfDone}, 3'b101);
    @(negedge clk);
    pinNConfig = 1'b0;
    @(negedge clk);
    check(cbNConfig === 1'b0, "R5 pin low passes", cbNConfig, 0);
    pinNConfig = 1'b1;
    writeCtrl(mkCtrl(1, 0, 3'b000, 0, 2'd0, 0, 0));
  endtask

  task automatic testWide;
    for (int r = 0; r < 4; r++) begin
      writeCtrl(mkCtrl(1, 0, 3'b000, 0, 2'(r), 1, 1));
      streamWord(32'h1357_9BDF + r, 1 << r, 1'b1, 1'b1, 1'b0, 32'd0, "R6 wide");
    end
  endtask

  task automatic testNarrow;
    writeCtrl(mkCtrl(1, 0, 3'b000, 0, 2'd0, 1, 0));
    streamWord(32'hCAFE_F00D, 1, 1'b0, 1'b1, 1'b0, 32'd0, "R8 narrow x1");
    writeCtrl(mkCtrl(1, 0, 3'b000, 0, 2'd2, 1, 0));
    streamWord(32'h8421_7E81, 4, 1'b0, 1'b1, 1'b0, 32'd0, "R8 narrow x4");
  endtask

  task automatic testGated;
    writeCtrl(mkCtrl(1, 0, 3'b000, 0, 2'd1, 0, 1));
    streamWord(32'h5555_AAAA, 2, 1'b1, 1'b0, 1'b0, 32'd0, "R7 gated wide");
    writeCtrl(mkCtrl(1, 0, 3'b000, 0, 2'd1, 0, 0));
    streamWord(32'h1234_5678, 2, 1'b0, 1'b0, 1'b0, 32'd0, "R7 gated narrow");
  endtask

  task automatic testCapture;
    writeCtrl(mkCtrl(1, 0, 3'b000, 0, 2'd2, 1, 1));
    streamWord(32'h0BAD_CAFE, 4, 1'b1, 1'b1, 1'b1, mkCtrl(1, 0, 3'b000, 0, 2'd0, 1, 0), "R10 old settings");
    streamWord(32'hFACE_B00C, 1, 1'b0, 1'b1, 1'b0, 32'd0, "R10 new settings");
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; regWe = 1'b0; regWdata = '0; inValid = 1'b0; inData = '0;
    pinNConfig = 1'b1; pinNStatus = 1'b0; pinConfDone = 1'b1;
    pinNce = 1'b0; pinPrReq = 1'b1; pinDclk = 1'b1; pinData = 32'h0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRegs();
    testPassThrough();
    testHostOwns();
    testPulls();
    testWide();
    testNarrow();
    testGated();
    testCapture();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule